// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits in front of a serial-flash controller and maps host addresses that fall inside a shared memory-mapped flash aperture onto one of several chip selects. Each chip select owns one 32-bit segment register that packs the start and end of its window inside the aperture. For every lookup the block returns, one cycle later, a one-hot chip select and the byte offset of the address inside the selected window. When no window claims the address it returns a miss.

A build-time parameter picks one of two register encodings. The coarse encoding counts in 8 MiB units and stores an exclusive end. The fine encoding counts in 1 MiB units and stores the last block of the window, so its end is inclusive. The same registers also drive a set of configuration flags. These flags report windows that overlap, that reach past the aperture, that add up to more than the aperture, or that are smaller than the minimum size of the chosen encoding.

Top module: `cs_window_decoder`

## Requirements
- R1: A write with `wr_en` high and `wr_idx` below `NUM_CS` loads `wr_data` into that chip select's segment register on the next clock edge. A write with `wr_idx` at or above `NUM_CS` changes neither the decode results nor the flags. The flags change only in the cycle after a write.
- R2: Coarse encoding (`FINE`=0): bits [23:16] hold the window start and bits [31:24] hold the exclusive end. Both are in 8 MiB units and are relative to `APT_BASE`.
- R3: Fine encoding (`FINE`=1): bits [11:4] hold the start in 1 MiB units. Bits [27:20] hold the last 1 MiB block of the window, so the exclusive end is (field + 1) MiB. Both are relative to `APT_BASE`.
- R4: A window whose end is not above its start is empty and decodes nothing. In the fine encoding an all-zero register is also empty. Every register is all-zero after reset.
- R5: A lookup presented with `lookup_vld` is answered exactly one cycle later with `res_vld` high. On a hit, `res_cs` has only bit i set for chip select i and `res_ofs` equals the address minus `APT_BASE` minus the window start. `res_vld` is low in the cycle after a cycle without a lookup.
- R6: An address below `APT_BASE`, or one that lies in no window, gives `res_miss`=1 with `res_cs`=0 and `res_ofs`=0.
- R7: When several windows contain the address, the lowest chip-select index wins.
- R8: `overlap_err` is high when some non-empty window i>0 starts below the end of a non-empty window i-1.
- R9: `size_err` is high when the sum of all window sizes exceeds `APT_SIZE`. An empty window counts as size 0.
- R10: `range_err` is high when some non-empty window ends above `APT_SIZE`.
- R11: `min_err` is high in the coarse encoding when any chip select, including an empty one, has a window below 8 MiB. In the fine encoding it is high when any non-empty window is below 2 MiB.
- R12: After reset `res_vld` is low. All windows are empty, so the fine variant shows no flag and the coarse variant shows only `min_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Segment register write strobe |
| wr_idx | input | IDX_W | Chip select whose register is written |
| wr_data | input | 32 | Segment register value |
| lookup_vld | input | 1 | Lookup request |
| lookup_addr | input | 32 | Host address to decode |
| res_vld | output | 1 | Lookup result valid, one cycle after the request |
| res_cs | output | NUM_CS | One-hot chip select that was hit |
| res_ofs | output | 32 | Byte offset inside the selected window |
| res_miss | output | 1 | No window contains the address |
| overlap_err | output | 1 | Neighbouring windows overlap or fall out of order |
| size_err | output | 1 | Total window size exceeds the aperture |
| range_err | output | 1 | A window reaches past the aperture |
| min_err | output | 1 | A window is below the minimum size |

## Verification
The hardest situations to reach are the ones where the registers contradict each other: overlapping windows where the priority rule decides the winner, windows that run past the aperture, and registers that one encoding reads as empty while the other reads them as a real window. The bench feeds the same register writes to a fine instance and a coarse instance. The values are picked so that one set of writes is clean for one encoding and contradictory for the other. After each set of writes, the bench sweeps addresses over the whole aperture and probes the first byte, last byte and first byte past every window.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned SPAN_W       = REG_W + 1;
  localparam int unsigned FLD_W        = 8;
  localparam int unsigned COARSE_SHIFT = 23;
  localparam int unsigned FINE_SHIFT   = 20;
  localparam int unsigned COARSE_LO    = 16;
  localparam int unsigned COARSE_HI    = 24;
  localparam int unsigned FINE_LO      = 4;
  localparam int unsigned FINE_HI      = 20;
  localparam int unsigned COARSE_MIN_SHIFT = 23;
  localparam int unsigned FINE_MIN_SHIFT   = 21;

  typedef struct packed {
    logic              en;
    logic [SPAN_W-1:0] lo;
    logic [SPAN_W-1:0] hi;
  } span_t;
endpackage

// File: rtl/cswd_seg_unpack.sv
module cswd_seg_unpack
  import cswd_pkg::*;
#(
  parameter bit FINE = 1'b1
) (
  input  logic [REG_W-1:0] seg,
  output span_t            span
);
  generate
    if (FINE) begin : g_fine
      logic [SPAN_W-1:0] lo, hi;
      always_comb begin
        lo = SPAN_W'(seg[FINE_LO +: FLD_W]) << FINE_SHIFT;
        hi = (SPAN_W'(seg[FINE_HI +: FLD_W]) << FINE_SHIFT) + (SPAN_W'(1) << FINE_SHIFT);
        span.lo = lo;
        span.hi = hi;
        span.en = (seg != '0) && (hi > lo);
      end
    end else begin : g_coarse
      logic [SPAN_W-1:0] lo, hi;
      logic unused_low;
      assign unused_low = ^seg[COARSE_LO-1:0];
      always_comb begin
        lo = SPAN_W'(seg[COARSE_LO +: FLD_W]) << COARSE_SHIFT;
        hi = SPAN_W'(seg[COARSE_HI +: FLD_W]) << COARSE_SHIFT;
        span.lo = lo;
        span.hi = hi;
        span.en = hi > lo;
      end
    end
  endgenerate
endmodule

// File: rtl/cswd_cfg_check.sv
module cswd_cfg_check
  import cswd_pkg::*;
#(
  parameter int unsigned     NUM_CS   = 5,
  parameter bit              FINE     = 1'b1,
  parameter logic [REG_W-1:0] APT_SIZE = 32'h1000_0000
) (
  input  span_t [NUM_CS-1:0] spans,
  output logic               overlap_err,
  output logic               size_err,
  output logic               range_err,
  output logic               min_err
);
  localparam int unsigned SUM_W = SPAN_W + $clog2(NUM_CS + 1);
  localparam logic [SPAN_W-1:0] MIN_SZ =
    SPAN_W'(1) << (FINE ? FINE_MIN_SHIFT : COARSE_MIN_SHIFT);

  logic [NUM_CS-1:0][SPAN_W-1:0] sz;
  logic [SUM_W-1:0]              sum;

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_sz
      assign sz[g] = spans[g].en ? (spans[g].hi - spans[g].lo) : '0;
    end
  endgenerate

  always_comb begin
    sum       = '0;
    range_err = 1'b0;
    min_err   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      sum = sum + SUM_W'(sz[i]);
      if (spans[i].en && (spans[i].hi > SPAN_W'(APT_SIZE))) range_err = 1'b1;
      if (FINE) begin
        if (spans[i].en && (sz[i] < MIN_SZ)) min_err = 1'b1;
      end else begin
        if (sz[i] < MIN_SZ) min_err = 1'b1;
      end
    end
    size_err = sum > SUM_W'(APT_SIZE);
  end

  always_comb begin
    overlap_err = 1'b0;
    for (int i = 1; i < NUM_CS; i++) begin
      if (spans[i].en && spans[i-1].en && (spans[i].lo < spans[i-1].hi))
        overlap_err = 1'b1;
    end
  end
endmodule

// File: rtl/cswd_hit_select.sv
module cswd_hit_select
  import cswd_pkg::*;
#(
  parameter int unsigned NUM_CS = 5
) (
  input  span_t [NUM_CS-1:0] spans,
  input  logic               in_apt,
  input  logic [SPAN_W-1:0]  rel,
  output logic [NUM_CS-1:0]  cs_onehot,
  output logic [SPAN_W-1:0]  ofs,
  output logic               miss
);
  logic [NUM_CS-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
      assign hit[g] = in_apt && spans[g].en && (rel >= spans[g].lo) && (rel < spans[g].hi);
    end
  endgenerate

  always_comb begin
    cs_onehot = '0;
    ofs       = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cs_onehot    = '0;
        cs_onehot[i] = 1'b1;
        ofs          = rel - spans[i].lo;
      end
    end
    miss = ~|hit;
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswd_pkg::*;
#(
  parameter int unsigned      NUM_CS   = 5,
  parameter bit               FINE     = 1'b1,
  parameter logic [REG_W-1:0] APT_BASE = 32'h2000_0000,
  parameter logic [REG_W-1:0] APT_SIZE = 32'h1000_0000,
  localparam int unsigned     IDX_W    = $clog2(NUM_CS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              lookup_vld,
  input  logic [REG_W-1:0]  lookup_addr,
  output logic              res_vld,
  output logic [NUM_CS-1:0] res_cs,
  output logic [REG_W-1:0]  res_ofs,
  output logic              res_miss,
  output logic              overlap_err,
  output logic              size_err,
  output logic              range_err,
  output logic              min_err
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // segment registers
  logic [NUM_CS-1:0][REG_W-1:0] seg_q, seg_d;
  logic                         seg_ce;

  always_comb begin
    seg_ce = wr_en && (int'(wr_idx) < NUM_CS);
    seg_d  = seg_q;
    if (seg_ce) seg_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  seg_q <= '0;
    else if (seg_ce)  seg_q <= seg_d;
  end

  // unpack every register into a window
  span_t [NUM_CS-1:0] spans;
  generate
    for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
      cswd_seg_unpack #(.FINE(FINE)) u_unpack (
        .seg  (seg_q[g]),
        .span (spans[g])
      );
    end
  endgenerate

  cswd_cfg_check #(.NUM_CS(NUM_CS), .FINE(FINE), .APT_SIZE(APT_SIZE)) u_cfg (
    .spans       (spans),
    .overlap_err (overlap_err),
    .size_err    (size_err),
    .range_err   (range_err),
    .min_err     (min_err)
  );

  // lookup
  logic              in_apt;
  logic [SPAN_W-1:0] rel;
  logic [NUM_CS-1:0] sel_cs;
  logic [SPAN_W-1:0] sel_ofs;
  logic              sel_miss;
  logic              unused_ofs_msb;

  assign in_apt = lookup_addr >= APT_BASE;
  assign rel    = SPAN_W'(lookup_addr) - SPAN_W'(APT_BASE);
  assign unused_ofs_msb = sel_ofs[SPAN_W-1];

  cswd_hit_select #(.NUM_CS(NUM_CS)) u_sel (
    .spans     (spans),
    .in_apt    (in_apt),
    .rel       (rel),
    .cs_onehot (sel_cs),
    .ofs       (sel_ofs),
    .miss      (sel_miss)
  );

  logic              vld_q, vld_d;
  logic [NUM_CS-1:0] cs_q, cs_d;
  logic [REG_W-1:0]  ofs_q, ofs_d;
  logic              miss_q, miss_d;

  always_comb begin
    vld_d  = lookup_vld;
    cs_d   = sel_cs;
    ofs_d  = sel_ofs[REG_W-1:0];
    miss_d = sel_miss;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      cs_q   <= '0;
      ofs_q  <= '0;
      miss_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (lookup_vld) begin
        cs_q   <= cs_d;
        ofs_q  <= ofs_d;
        miss_q <= miss_d;
      end
    end
  end

  assign res_vld  = vld_q;
  assign res_cs   = cs_q;
  assign res_ofs  = ofs_q;
  assign res_miss = miss_q;
endmodule

// File: rtl/cswd_checker.sv
module cswd_checker #(
  parameter int unsigned NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              lookup_vld,
  input logic              res_vld,
  input logic [NUM_CS-1:0] res_cs,
  input logic [31:0]       res_ofs,
  input logic              res_miss,
  input logic              overlap_err,
  input logic              size_err,
  input logic              range_err,
  input logic              min_err
);
  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_vld |=> res_vld); // R5
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_vld |=> !res_vld); // R5
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_miss) |-> ($countones(res_cs) == 1)); // R5
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_miss) |-> (res_cs == '0 && res_ofs == '0)); // R6
  AST_FLAGS_NEED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({overlap_err, size_err, range_err, min_err})); // R1
endmodule

bind cs_window_decoder cswd_checker #(.NUM_CS(NUM_CS)) u_cswd_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .lookup_vld  (lookup_vld),
  .res_vld     (res_vld),
  .res_cs      (res_cs),
  .res_ofs     (res_ofs),
  .res_miss    (res_miss),
  .overlap_err (overlap_err),
  .size_err    (size_err),
  .range_err   (range_err),
  .min_err     (min_err)
);

// File: tb/cs_window_decoder_bench.sv
module cs_window_decoder_bench;
  localparam int          NCS  = 5;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam longint      FSZ  = 64'h1000_0000;
  localparam longint      CSZ  = 64'h4000_0000;
  localparam longint      MB   = 64'h10_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en, lookup_vld;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data, lookup_addr;

  logic          f_vld, f_miss, f_ovl, f_size, f_rng, f_min;
  logic [NCS-1:0] f_cs;
  logic [31:0]   f_ofs;
  logic          c_vld, c_miss, c_ovl, c_size, c_rng, c_min;
  logic [NCS-1:0] c_cs;
  logic [31:0]   c_ofs;

  cs_window_decoder #(.NUM_CS(NCS), .FINE(1'b1), .APT_BASE(BASE), .APT_SIZE(32'h1000_0000)) u_cs_window_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lookup_vld(lookup_vld), .lookup_addr(lookup_addr),
    .res_vld(f_vld), .res_cs(f_cs), .res_ofs(f_ofs), .res_miss(f_miss),
    .overlap_err(f_ovl), .size_err(f_size), .range_err(f_rng), .min_err(f_min));

  cs_window_decoder #(.NUM_CS(NCS), .FINE(1'b0), .APT_BASE(BASE), .APT_SIZE(32'h4000_0000)) u_cs_window_decoder_coarse (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .lookup_vld(lookup_vld), .lookup_addr(lookup_addr),
    .res_vld(c_vld), .res_cs(c_cs), .res_ofs(c_ofs), .res_miss(c_miss),
    .overlap_err(c_ovl), .size_err(c_size), .range_err(c_rng), .min_err(c_min));

  int total = 0;
  int bad   = 0;
  logic [31:0] mreg [NCS];

  // reference model from the register layouts
  function automatic longint m_lo(bit fine, logic [31:0] r);
    return fine ? longint'(r[11:4]) * MB : longint'(r[23:16]) * 8 * MB;
  endfunction
  function automatic longint m_hi(bit fine, logic [31:0] r);
    return fine ? (longint'(r[27:20]) + 1) * MB : longint'(r[31:24]) * 8 * MB;
  endfunction
  function automatic bit m_en(bit fine, logic [31:0] r);
    return (fine ? (r != 0) : 1'b1) && (m_hi(fine, r) > m_lo(fine, r));
  endfunction

  function automatic logic [63:0] exp_pack(bit fine, logic [31:0] a);
    longint rel = longint'(a) - longint'(BASE);
    logic [NCS-1:0] cs = '0;
    logic [31:0] ofs = '0;
    bit miss = 1'b1;
    if (rel >= 0) begin
      for (int i = 0; i < NCS; i++) begin
        if (miss && m_en(fine, mreg[i]) && rel >= m_lo(fine, mreg[i]) && rel < m_hi(fine, mreg[i])) begin
          miss = 1'b0;
          cs[i] = 1'b1;
          ofs = 32'(rel - m_lo(fine, mreg[i]));
        end
      end
    end
    return {25'd0, 1'b1, miss, cs, ofs};
  endfunction

  function automatic logic [3:0] exp_flags(bit fine, longint apt);
    longint sum = 0;
    logic ovl = 0, rng = 0, mn = 0;
    for (int i = 0; i < NCS; i++) begin
      longint sz = m_en(fine, mreg[i]) ? m_hi(fine, mreg[i]) - m_lo(fine, mreg[i]) : 0;
      sum += sz;
      if (m_en(fine, mreg[i]) && m_hi(fine, mreg[i]) > apt) rng = 1;
      if (fine) begin
        if (m_en(fine, mreg[i]) && sz < 2 * MB) mn = 1;
      end else if (sz < 8 * MB) mn = 1;
      if (i > 0 && m_en(fine, mreg[i]) && m_en(fine, mreg[i-1]) &&
          m_lo(fine, mreg[i]) < m_hi(fine, mreg[i-1])) ovl = 1;
    end
    return {ovl, sum > apt, rng, mn};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < NCS) mreg[idx] = d;
  endtask

  task automatic look(logic [31:0] a, string tag);
    logic [63:0] ef, ec;
    @(negedge clk);
    lookup_vld = 1'b1; lookup_addr = a;
    @(negedge clk);
    lookup_vld = 1'b0;
    ef = exp_pack(1'b1, a);
    ec = exp_pack(1'b0, a);
    chk(ef[37] ? {tag, " R6 fine"} : {tag, " R3 R5 fine"},
        {25'd0, f_vld, f_miss, f_cs, f_ofs}, ef);
    chk(ec[37] ? {tag, " R6 coarse"} : {tag, " R2 R5 coarse"},
        {25'd0, c_vld, c_miss, c_cs, c_ofs}, ec);
  endtask

  task automatic chk_flags();
    logic [3:0] ef = exp_flags(1'b1, FSZ);
    logic [3:0] ec = exp_flags(1'b0, CSZ);
    chk("R8 fine overlap",   64'(f_ovl),  64'(ef[3]));
    chk("R9 fine size",      64'(f_size), 64'(ef[2]));
    chk("R10 fine range",    64'(f_rng),  64'(ef[1]));
    chk("R11 fine minimum",  64'(f_min),  64'(ef[0]));
    chk("R8 coarse overlap", 64'(c_ovl),  64'(ec[3]));
    chk("R9 coarse size",    64'(c_size), 64'(ec[2]));
    chk("R10 coarse range",  64'(c_rng),  64'(ec[1]));
    chk("R11 coarse minimum",64'(c_min),  64'(ec[0]));
  endtask

  task automatic sweep(string tag);
    for (longint o = -MB; o < FSZ + 2 * MB; o += MB / 2) look(32'(longint'(BASE) + o), tag);
    for (longint o = 0; o < CSZ + 64 * MB; o += 8 * MB) look(32'(longint'(BASE) + o), tag);
    for (int i = 0; i < NCS; i++) begin
      for (int v = 0; v < 2; v++) begin
        if (m_en(v[0], mreg[i])) begin
          look(32'(longint'(BASE) + m_lo(v[0], mreg[i])), tag);
          look(32'(longint'(BASE) + m_hi(v[0], mreg[i]) - 1), tag);
          look(32'(longint'(BASE) + m_hi(v[0], mreg[i])), tag);
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    lookup_vld = 1'b0; lookup_addr = '0;
    for (int i = 0; i < NCS; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12: reset state
    chk("R12 fine res_vld",   64'(f_vld), 64'd0);
    chk("R12 coarse res_vld", 64'(c_vld), 64'd0);
    chk("R12 fine flags",   64'({f_ovl, f_size, f_rng, f_min}), 64'(4'b0000));
    chk("R12 coarse flags", 64'({c_ovl, c_size, c_rng, c_min}), 64'(4'b0001));
    sweep("R4 R12");

    // fine-clean layout, one empty register
    wr(0, 32'h00F0_0000);
    wr(1, 32'h02F0_0100);
    wr(2, 32'h07F0_0400);
    wr(3, 32'h0000_0000);
    wr(4, 32'h0FF0_0C80);
    chk_flags();
    sweep("R1 R4");

    // fine overlap: cs1 starts inside cs0
    wr(1, 32'h02F0_00A0);
    chk_flags();
    sweep("R7");

    // coarse-clean layout filling the coarse aperture exactly
    wr(0, 32'h0200_0000);
    wr(1, 32'h0602_0000);
    wr(2, 32'h4006_0000);
    wr(3, 32'h6040_0000);
    wr(4, 32'h8060_0000);
    chk_flags();
    sweep("R2");

    // coarse window past the aperture
    wr(4, 32'h9060_0000);
    chk_flags();
    sweep("R10 R9");

    // coarse overlap plus an empty coarse window
    wr(1, 32'h0601_0000);
    wr(2, 32'h0004_0000);
    chk_flags();
    sweep("R4 R7");

    // writes to indices beyond the last chip select are ignored
    wr(5, 32'hFFFF_FFFF);
    wr(6, 32'h0100_0010);
    wr(7, 32'h0000_0000);
    chk_flags();
    sweep("R1 ignored");

    // fine 1 MiB window below the fine minimum
    wr(4, 32'h0FA0_0FA0);
    chk_flags();
    sweep("R11 R3");

    finish_run();
  end
endmodule